// File: doc/BRIEF.md
# Dual Parallel Port with Per-Bit Direction Control

This block provides two byte-wide parallel ports for a small controller. Each bit of each port can be set to drive its pad or to be read from it. For every port the block holds two registers: an output latch that holds the value to drive, and a direction register that picks, bit by bit, whether the pad is driven. A simple internal register bus reaches both registers. The bus has an address, a write strobe, write data and combinational read data.

The pads themselves sit outside the block. The block supplies a drive value and a drive enable for every bit, and takes in the pad level on a plain input bus. Pad levels pass through a two-flop synchroniser before they are used. A read of a port register gives a mix for each bit: bits set to drive return the latch, and bits set to sense return the synchronised pad level. Writes to the port register land in the latch whatever the direction is. Reset makes every bit an input but keeps the latch contents.

Top module: `pio_bank`

## Requirements
- R1: While reset is low, and at the first clock after reset, every drive enable (`pin_oe`) is 0, so every bit is an input.
- R2: Writing the direction register of a port sets `pin_oe` for that port, bit for bit, from the clock edge of the write onward (1 = drive, 0 = sense).
- R3: A write to a port register stores the byte in that port's output latch, including bits that are currently inputs. Such a bit shows the stored value once its direction bit is later set.
- R4: For every bit whose drive enable is 1, `pin_out` equals the latch bit.
- R5: A read of a port register returns, for each bit, the latch bit if its direction bit is 1 and the synchronised pad level if it is 0.
- R6: A change on `pin_in` appears in read data after two rising clock edges. Read data sampled after only one edge still shows the old level.
- R7: The address map is fixed: port A register at 0x0000, port B register at 0x0001, port A direction at 0x0004, port B direction at 0x0005. Port A is bits 7:0 of the pin buses and port B is bits 15:8.
- R8: A read of a direction register returns its current contents.
- R9: Reads of any other address return 0x00. Writes to any other address change neither `pin_out` nor `pin_oe`, nor any register.
- R10: Reset leaves the output latches unchanged. After reset, setting a direction bit drives the value that was latched before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (13) | Register bus address |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PORTS*DATA_W (16) | Pad levels, port A in the low byte |
| pin_out | output | NUM_PORTS*DATA_W (16) | Pad drive values (output latches) |
| pin_oe | output | NUM_PORTS*DATA_W (16) | Pad drive enables (direction registers) |

## Verification
Register writes show on `pin_out`, `pin_oe` and read data straight after the edge that samples the strobe, with no extra latency. A pad change needs two edges before it reaches read data, while the address-to-read path has none. The bench drives every input at the falling edge and compares all outputs one time step later against a behavioural model. The model is updated only after the rising edge, and it holds a two-entry pipeline of past pad values, so every check lands in the cycle the requirement gives. Latch bits never written are tracked as unknown and masked from comparison until a write defines them.

// File: rtl/pio_pkg.sv
package pio_pkg;

   // Which register of a lane the current bus address selects.
   typedef enum logic [1:0] {
      PIO_SEL_NONE = 2'd0,
      PIO_SEL_DATA = 2'd1,
      PIO_SEL_DIR  = 2'd2
   } pio_sel_e;

   // Default register placement: port registers start at this offset,
   // direction registers at the second offset.
   localparam int unsigned PIO_DATA_BASE_DEF = 0;
   localparam int unsigned PIO_DIR_BASE_DEF  = 4;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pio_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
               stage_q[s] <= '0;
            end
         end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/pio_decode.sv
module pio_decode
   import pio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned DATA_BASE = PIO_DATA_BASE_DEF,
   parameter int unsigned DIR_BASE  = PIO_DIR_BASE_DEF
) (
   input  logic [ADDR_W-1:0] addr_i,
   output pio_sel_e          sel_o [NUM_PORTS]
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int unsigned DATA_ADDR = DATA_BASE + p;
      localparam int unsigned DIR_ADDR  = DIR_BASE + p;
      localparam logic [ADDR_W-1:0] DATA_A = DATA_ADDR[ADDR_W-1:0];
      localparam logic [ADDR_W-1:0] DIR_A  = DIR_ADDR[ADDR_W-1:0];

      always_comb begin
         if (addr_i == DATA_A) begin
            sel_o[p] = PIO_SEL_DATA;
         end else if (addr_i == DIR_A) begin
            sel_o[p] = PIO_SEL_DIR;
         end else begin
            sel_o[p] = PIO_SEL_NONE;
         end
      end
   end

endmodule

// File: rtl/pio_lane.sv
module pio_lane
   import pio_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pio_sel_e         sel_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] pad_o,
   output logic [WIDTH-1:0] pad_oe_o,
   output logic [WIDTH-1:0] rd_o
);

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pad_sync;
   logic [WIDTH-1:0] mixed;
   logic             wr_latch;
   logic             wr_dir;

   assign wr_latch = wr_i && (sel_i == PIO_SEL_DATA);
   assign wr_dir   = wr_i && (sel_i == PIO_SEL_DIR);

   // Output latch: no reset, contents survive a reset.
   always_ff @(posedge clk) begin
      if (wr_latch) begin
         latch_q <= wdata_i;
      end
   end

   // Direction register: every bit an input after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wdata_i;
      end
   end

   pio_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_i),
      .q_o   (pad_sync)
   );

   assign mixed = (dir_q & latch_q) | (~dir_q & pad_sync);

   always_comb begin
      unique case (sel_i)
         PIO_SEL_DATA: rd_o = mixed;
         PIO_SEL_DIR:  rd_o = dir_q;
         default:      rd_o = '0;
      endcase
   end

   assign pad_o    = latch_q;
   assign pad_oe_o = dir_q;

endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_PORTS   = 2,
   parameter int unsigned DATA_BASE   = PIO_DATA_BASE_DEF,
   parameter int unsigned DIR_BASE    = PIO_DIR_BASE_DEF,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic                          reg_wr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic [NUM_PORTS*DATA_W-1:0]   pin_in,
   output logic [NUM_PORTS*DATA_W-1:0]   pin_out,
   output logic [NUM_PORTS*DATA_W-1:0]   pin_oe
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;
   localparam int unsigned DATA_END  = DATA_BASE + NUM_PORTS;
   localparam int unsigned DIR_END   = DIR_BASE + NUM_PORTS;

   // Elaboration-time parameter checks.
   if (DATA_W < 1 || NUM_PORTS < 1) begin : g_bad_size
      $error("pio_bank: DATA_W and NUM_PORTS must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
      $error("pio_bank: ADDR_W out of range");
   end
   if (DIR_BASE < DATA_END && DATA_BASE < DIR_END) begin : g_overlap
      $error("pio_bank: port and direction address windows overlap");
   end
   if (DATA_END > ADDR_SPAN || DIR_END > ADDR_SPAN) begin : g_out_of_space
      $error("pio_bank: register window exceeds the address space");
   end

   pio_sel_e          sel      [NUM_PORTS];
   logic [DATA_W-1:0] lane_rd  [NUM_PORTS];

   pio_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_PORTS (NUM_PORTS),
      .DATA_BASE (DATA_BASE),
      .DIR_BASE  (DIR_BASE)
   ) decode_i (
      .addr_i (reg_addr),
      .sel_o  (sel)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
      pio_lane #(
         .WIDTH       (DATA_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) lane_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_i    (sel[p]),
         .wr_i     (reg_wr),
         .wdata_i  (reg_wdata),
         .pad_i    (pin_in [p*DATA_W +: DATA_W]),
         .pad_o    (pin_out[p*DATA_W +: DATA_W]),
         .pad_oe_o (pin_oe [p*DATA_W +: DATA_W]),
         .rd_o     (lane_rd[p])
      );
   end

   // Lanes return zero unless selected, so an OR merges them.
   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         reg_rdata = reg_rdata | lane_rd[p];
      end
   end

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned DATA_BASE = 0,
   parameter int unsigned DIR_BASE  = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic                        reg_wr,
   input logic [DATA_W-1:0]           reg_wdata,
   input logic [DATA_W-1:0]           reg_rdata,
   input logic [NUM_PORTS*DATA_W-1:0] pin_out,
   input logic [NUM_PORTS*DATA_W-1:0] pin_oe
);

   logic mapped;

   always_comb begin
      mapped = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (int'(reg_addr) == DATA_BASE + p || int'(reg_addr) == DIR_BASE + p) begin
            mapped = 1'b1;
         end
      end
   end

   AST_RESET_INPUTS: assert property (@(posedge clk)
      !rst_n |=> pin_oe == '0);  // R1

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> reg_rdata == '0);  // R9

   AST_UNMAPPED_WRITE_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !mapped) |=> $stable(pin_oe) && $stable(pin_out));  // R9

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int unsigned DA = DATA_BASE + p;
      localparam int unsigned RA = DIR_BASE + p;

      AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && int'(reg_addr) == RA) |=>
            pin_oe[p*DATA_W +: DATA_W] == $past(reg_wdata));  // R2

      AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(reg_wr && int'(reg_addr) == RA) |=>
            $stable(pin_oe[p*DATA_W +: DATA_W]));  // R2

      AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && int'(reg_addr) == DA) |=>
            pin_out[p*DATA_W +: DATA_W] == $past(reg_wdata));  // R3

      AST_READ_DRIVEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(reg_addr) == DA) |->
            ((reg_rdata ^ pin_out[p*DATA_W +: DATA_W]) & pin_oe[p*DATA_W +: DATA_W]) == '0);  // R5

      AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(reg_addr) == RA) |-> reg_rdata == pin_oe[p*DATA_W +: DATA_W]);  // R8
   end

endmodule

bind pio_bank pio_bank_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_PORTS (NUM_PORTS),
   .DATA_BASE (DATA_BASE),
   .DIR_BASE  (DIR_BASE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [15:0]   pin_in = '0;
   logic [15:0]   pin_out;
   logic [15:0]   pin_oe;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   // Behavioural model state
   logic [7:0] m_dir   [NP];
   logic [7:0] m_lat   [NP];
   logic [7:0] m_known [NP];
   logic [15:0] pin_hist [$];   // pad values captured at past edges
   logic [15:0] pins_drv = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   function automatic logic [15:0] synced();
      if (pin_hist.size() < 2) return 16'h0;
      return pin_hist[pin_hist.size()-2];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [7:0] exp_rd = 8'h00;
      logic [7:0] mask = 8'hFF;
      logic [15:0] s = synced();
      for (int p = 0; p < NP; p++) begin
         if (int'(reg_addr) == p) begin
            exp_rd = (m_dir[p] & m_lat[p]) | (~m_dir[p] & s[p*8 +: 8]);
            mask   = ~(m_dir[p] & ~m_known[p]);
         end else if (int'(reg_addr) == 4 + p) begin
            exp_rd = m_dir[p];
         end
      end
      check(tag, "rdata", {8'h00, reg_rdata & mask}, {8'h00, exp_rd & mask});
      check(tag, "pin_oe", pin_oe, {m_dir[1], m_dir[0]});
      for (int p = 0; p < NP; p++) begin
         logic [7:0] m = m_dir[p] & m_known[p];
         check(tag, "pin_out", {8'h00, pin_out[p*8 +: 8] & m}, {8'h00, m_lat[p] & m});
      end
   endtask

   // One bus cycle: drive at the falling edge, compare, then advance the model.
   task automatic cyc(input logic [AW-1:0] a, input logic we, input logic [7:0] d,
                      input string tag);
      @(negedge clk);
      reg_addr = a; reg_wr = we; reg_wdata = d; pin_in = pins_drv;
      #1;
      compare(tag);
      @(posedge clk);
      if (!rst_n) begin
         pin_hist.delete();
      end else begin
         pin_hist.push_back(pins_drv);
         if (pin_hist.size() > 2) void'(pin_hist.pop_front());
         if (we) begin
            for (int p = 0; p < NP; p++) begin
               if (int'(a) == p) begin m_lat[p] = d; m_known[p] = 8'hFF; end
               if (int'(a) == 4 + p) m_dir[p] = d;
            end
         end
      end
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int p = 0; p < NP; p++) m_dir[p] = 8'h00;
      pin_hist.delete();
   endtask

   task automatic leave_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) begin
         m_dir[p] = 8'h00; m_lat[p] = 8'h00; m_known[p] = 8'h00;
      end
      // R1: reset state
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) cyc(13'h0004, 1'b0, 8'h00, "R1");
      leave_reset();
      cyc(13'h0005, 1'b0, 8'h00, "R1");
      cyc(13'h0004, 1'b0, 8'h00, "R8");

      // R6: pad change takes two edges to reach read data
      pins_drv = 16'h3C5A;
      for (int i = 0; i < 4; i++) cyc(13'h0000, 1'b0, 8'h00, "R6");
      pins_drv = 16'hC3A5;
      for (int i = 0; i < 4; i++) cyc(13'h0001, 1'b0, 8'h00, "R6");

      // R3: write to an all-input port lands in the latch only
      cyc(13'h0000, 1'b1, 8'h96, "R3");
      cyc(13'h0000, 1'b0, 8'h00, "R3");
      // R2 / R4 / R5: make the upper nibble of A drive
      cyc(13'h0004, 1'b1, 8'hF0, "R2");
      cyc(13'h0000, 1'b0, 8'h00, "R5");
      cyc(13'h0004, 1'b0, 8'h00, "R8");
      pins_drv = 16'h0F0F;
      for (int i = 0; i < 3; i++) cyc(13'h0000, 1'b0, 8'h00, "R5");
      cyc(13'h0000, 1'b1, 8'h5A, "R4");
      cyc(13'h0000, 1'b0, 8'h00, "R4");

      // R7: port B at its own addresses
      cyc(13'h0001, 1'b1, 8'hA5, "R7");
      cyc(13'h0005, 1'b1, 8'hFF, "R7");
      cyc(13'h0001, 1'b0, 8'h00, "R7");
      cyc(13'h0005, 1'b1, 8'h0F, "R7");
      cyc(13'h0005, 1'b0, 8'h00, "R8");
      cyc(13'h0001, 1'b0, 8'h00, "R5");

      // R9: unmapped addresses
      cyc(13'h0002, 1'b1, 8'hFF, "R9");
      cyc(13'h0003, 1'b1, 8'h77, "R9");
      cyc(13'h0006, 1'b1, 8'h11, "R9");
      cyc(13'h1FFF, 1'b1, 8'h22, "R9");
      cyc(13'h0002, 1'b0, 8'h00, "R9");
      cyc(13'h0008, 1'b0, 8'h00, "R9");
      cyc(13'h0000, 1'b0, 8'h00, "R9");
      cyc(13'h0001, 1'b0, 8'h00, "R9");

      // R10: latches survive a reset
      cyc(13'h0000, 1'b1, 8'hC6, "R10");
      cyc(13'h0001, 1'b1, 8'h39, "R10");
      enter_reset();
      for (int i = 0; i < 2; i++) cyc(13'h0004, 1'b0, 8'h00, "R1");
      leave_reset();
      cyc(13'h0000, 1'b0, 8'h00, "R10");
      cyc(13'h0004, 1'b1, 8'hFF, "R10");
      cyc(13'h0005, 1'b1, 8'hFF, "R10");
      cyc(13'h0000, 1'b0, 8'h00, "R10");
      cyc(13'h0001, 1'b0, 8'h00, "R10");

      // Walking patterns over direction and pads (R5, R6)
      for (int k = 0; k < 8; k++) begin
         pins_drv = {8'(8'h01 << k), 8'(~(8'h01 << k))};
         cyc(13'h0004, 1'b1, 8'(8'h01 << k), "R2");
         cyc(13'h0005, 1'b1, 8'(8'h80 >> k), "R2");
         cyc(13'h0000, 1'b1, 8'(k * 37), "R3");
         cyc(13'h0000, 1'b0, 8'h00, "R5");
         cyc(13'h0001, 1'b0, 8'h00, "R6");
         cyc(13'h0001, 1'b0, 8'h00, "R5");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule